// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block is the control front end of an on-chip NOR flash array. Software reaches it through a small 32-bit register bus: a key register, a status register and a control register. Once the control register is opened with a two-word key sequence, software picks a sector erase, a mass erase or program mode. A sector or mass erase is started by a start bit. A program is started by one data write into the flash address range, made at the width that was configured. The block checks each request against the lock state, the busy state, the access width, the alignment and a per-sector protect vector. Then it either issues a one-cycle command to the array or records a sticky error flag.

The array is 1 MiB and has twelve sectors. Sectors 0 to 3 are 16 KiB each, sector 4 is 64 KiB, and sectors 5 to 11 are 128 KiB each. While an accepted operation runs, a busy flag stays high. It falls in the cycle after the array reports completion. Error flags stay set until software writes a one to the bit position of each flag.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the block is locked. Control reads 0x8000_0000, status reads 0 and `arr_start` is low.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) unlocks the block, and control bit 31 then reads 0.
- R3: While the block is locked, control writes (offset 0x10) have no effect. A key write with any other value while locked keeps the block locked until reset, even if the correct keys follow.
- R4: A control write with bit 31 set relocks the block. The other control fields take the written value.
- R5: A control write that has bit 16 (start) and bit 1 (sector erase) set, with sector number bits 6:3 below 12, pulses `arr_start` for one cycle with `arr_op`=2 and `arr_sector` equal to that number. Status bit 16 (busy) is set from that edge until the edge after `arr_done`.
- R6: A start with bit 2 (mass erase) set launches `arr_op`=3. If any protect bit is set, it flags the protection error instead. Mass erase takes precedence over sector erase.
- R7: With bit 0 (program) set, a data write whose size code equals control bits 9:8 (0 byte, 1 halfword, 2 word, 3 doubleword) and is aligned launches `arr_op`=1. The pulse carries the address, its sector, the size and the data.
- R8: A program-mode data write whose size code differs from bits 9:8 sets status bit 6 and starts nothing.
- R9: A program-mode data write whose address is not a multiple of the access size sets status bit 5 and starts nothing.
- R10: Status bit 7 (sequence error) is set, and nothing starts, in three cases: a data write while locked, while bit 0 is clear, or while busy; a start while busy; or a start with neither erase bit set.
- R11: An erase or program aimed at a sector whose `wp_sector` bit is set sets status bit 4 and starts nothing.
- R12: A sector-erase start whose sector number is 12 or more sets status bit 1 and starts nothing.
- R13: Writing a one to status bits 7, 6, 5, 4 or 1 clears only those flags. If a flag is cleared and raised in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| fw_valid | input | 1 | Data write into the flash range |
| fw_addr | input | 20 | Byte address inside the array |
| fw_size | input | 2 | Access size code of the data write |
| fw_data | input | 64 | Data of the write |
| wp_sector | input | 12 | Per-sector write-protect bits |
| arr_start | output | 1 | One-cycle command pulse to the array |
| arr_op | output | 2 | 1 program, 2 sector erase, 3 mass erase |
| arr_sector | output | 4 | Target sector of the command |
| arr_addr | output | 20 | Program address |
| arr_size | output | 2 | Program size code |
| arr_wdata | output | 64 | Program data |
| arr_done | input | 1 | Array finished the operation |

## Verification
A status write that clears flags and a fault that raises one of those flags can fall in the same cycle. The bench provokes this by driving a write-one-to-clear of the sequence flag on the register bus in the same cycle as a data write made with program mode off. It expects the flag to read back set and an unrelated flag that was already set to remain untouched. A second collision is a start request while an erase is still busy. The bench issues it a few cycles after launch and judges it by the absence of a second `arr_start` pulse, a raised sequence flag and a busy flag that still falls only after `arr_done`.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 64;
  localparam int N_SECT = 12;
  localparam int SNB_W  = 4;
  localparam int SN_EXT = 1 << SNB_W;

  localparam logic [7:0] OFS_KEY  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_CTRL = 8'h10;

  localparam logic [31:0] KEY_A = 32'h4567_0123;
  localparam logic [31:0] KEY_B = 32'hCDEF_89AB;

  localparam int CB_PG = 0, CB_SER = 1, CB_MER = 2, CB_SNB = 3;
  localparam int CB_PSZ = 8, CB_STRT = 16, CB_LOCK = 31;
  localparam int SB_OPE = 1, SB_WRP = 4, SB_ALN = 5, SB_PAR = 6, SB_SEQ = 7, SB_BSY = 16;

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_PROG = 2'd1, OP_SERASE = 2'd2, OP_MERASE = 2'd3} op_e;
  typedef enum logic [1:0] {K_LOCK, K_HALF, K_OPEN, K_DEAD} key_st_e;

  typedef struct packed {
    logic seq;
    logic par;
    logic aln;
    logic wrp;
    logic ope;
  } err_t;

  // Sector index from a byte address: 4 x 16K, 1 x 64K, 7 x 128K.
  function automatic logic [SNB_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:16] == '0) return SNB_W'(a[15:14]);
    else if (a[ADDR_W-1:17] == '0) return SNB_W'(4);
    else return SNB_W'(4) + SNB_W'(a[ADDR_W-1:17]);
  endfunction

  // True when the address is not a multiple of 2**size bytes.
  function automatic logic misaligned(input logic [2:0] lo, input logic [1:0] size);
    logic [3:0] m;
    m = (4'd1 << size) - 4'd1;
    return |(lo & m[2:0]);
  endfunction

  function automatic logic [31:0] stat_word(input err_t e, input logic busy);
    logic [31:0] w;
    w = '0;
    w[SB_SEQ] = e.seq;
    w[SB_PAR] = e.par;
    w[SB_ALN] = e.aln;
    w[SB_WRP] = e.wrp;
    w[SB_OPE] = e.ope;
    w[SB_BSY] = busy;
    return w;
  endfunction
endpackage

// File: rtl/fpe_ctrl_reg.sv
module fpe_ctrl_reg
  import fpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic              unlocked,
  output logic              pg,
  output logic [1:0]        psize,
  output logic              strt_req,
  output logic              cmd_ser,
  output logic              cmd_mer,
  output logic [SNB_W-1:0]  cmd_snb,
  output logic [31:0]       ctrl_rd
);
  key_st_e          st, st_n;
  logic             ser, mer;
  logic [SNB_W-1:0] snb;
  logic             key_wr, ctrl_wr;

  assign key_wr   = we && (addr == OFS_KEY);
  assign ctrl_wr  = we && (addr == OFS_CTRL) && (st == K_OPEN);
  assign unlocked = (st == K_OPEN);

  always_comb begin
    st_n = st;
    case (st)
      K_LOCK: if (key_wr) st_n = (wdata == KEY_A) ? K_HALF : K_DEAD;
      K_HALF: if (key_wr) st_n = (wdata == KEY_B) ? K_OPEN : K_DEAD;
      K_OPEN: if (ctrl_wr && wdata[CB_LOCK]) st_n = K_LOCK;
      default: st_n = K_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= K_LOCK;
      pg    <= 1'b0;
      ser   <= 1'b0;
      mer   <= 1'b0;
      snb   <= '0;
      psize <= 2'd0;
    end else begin
      st <= st_n;
      if (ctrl_wr) begin
        pg    <= wdata[CB_PG];
        ser   <= wdata[CB_SER];
        mer   <= wdata[CB_MER];
        snb   <= wdata[CB_SNB +: SNB_W];
        psize <= wdata[CB_PSZ +: 2];
      end
    end
  end

  // The start request uses the fields written with it.
  assign strt_req = ctrl_wr && wdata[CB_STRT];
  assign cmd_ser  = wdata[CB_SER];
  assign cmd_mer  = wdata[CB_MER];
  assign cmd_snb  = wdata[CB_SNB +: SNB_W];

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_LOCK]             = !unlocked;
    ctrl_rd[CB_PSZ +: 2]         = psize;
    ctrl_rd[CB_SNB +: SNB_W]     = snb;
    ctrl_rd[CB_MER]              = mer;
    ctrl_rd[CB_SER]              = ser;
    ctrl_rd[CB_PG]               = pg;
  end
endmodule

// File: rtl/fpe_launch.sv
module fpe_launch
  import fpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strt_req,
  input  logic              cmd_ser,
  input  logic              cmd_mer,
  input  logic [SNB_W-1:0]  cmd_snb,
  input  logic              unlocked,
  input  logic              pg,
  input  logic [1:0]        psize,
  input  logic              busy,
  input  logic              fw_valid,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [1:0]        fw_size,
  input  logic [DATA_W-1:0] fw_data,
  input  logic [N_SECT-1:0] wp,
  output err_t              err_set,
  output logic              launch,
  output logic              arr_start,
  output op_e               arr_op,
  output logic [SNB_W-1:0]  arr_sector,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [1:0]        arr_size,
  output logic [DATA_W-1:0] arr_wdata
);
  logic [SN_EXT-1:0] wp_ext;
  logic [SNB_W-1:0]  fw_sec;
  logic              erase_go, prog_go;
  op_e               erase_op;

  assign wp_ext = SN_EXT'(wp);
  assign fw_sec = sector_of(fw_addr);

  always_comb begin
    err_set  = '0;
    erase_go = 1'b0;
    prog_go  = 1'b0;
    erase_op = OP_SERASE;
    if (strt_req) begin
      if (busy || (!cmd_ser && !cmd_mer)) err_set.seq = 1'b1;
      else if (cmd_mer) begin
        erase_op = OP_MERASE;
        if (|wp) err_set.wrp = 1'b1;
        else erase_go = 1'b1;
      end
      else if (cmd_snb >= SNB_W'(N_SECT)) err_set.ope = 1'b1;
      else if (wp_ext[cmd_snb]) err_set.wrp = 1'b1;
      else erase_go = 1'b1;
    end
    if (fw_valid) begin
      if (!unlocked || !pg || busy || erase_go) err_set.seq = 1'b1;
      else if (fw_size != psize) err_set.par = 1'b1;
      else if (misaligned(fw_addr[2:0], fw_size)) err_set.aln = 1'b1;
      else if (wp_ext[fw_sec]) err_set.wrp = 1'b1;
      else prog_go = 1'b1;
    end
  end

  assign launch = erase_go || prog_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_start  <= 1'b0;
      arr_op     <= OP_NONE;
      arr_sector <= '0;
      arr_addr   <= '0;
      arr_size   <= 2'd0;
      arr_wdata  <= '0;
    end else begin
      arr_start <= launch;
      if (erase_go) begin
        arr_op     <= erase_op;
        arr_sector <= (erase_op == OP_MERASE) ? '0 : cmd_snb;
      end else if (prog_go) begin
        arr_op     <= OP_PROG;
        arr_sector <= fw_sec;
        arr_addr   <= fw_addr;
        arr_size   <= fw_size;
        arr_wdata  <= fw_data;
      end
    end
  end
endmodule

// File: rtl/fpe_status.sv
module fpe_status
  import fpe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  err_t clr,
  input  err_t err_set,
  input  logic launch,
  input  logic arr_done,
  output err_t flags,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      busy  <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | err_set;
      if (launch) busy <= 1'b1;
      else if (arr_done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import fpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              fw_valid,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [1:0]        fw_size,
  input  logic [DATA_W-1:0] fw_data,
  input  logic [N_SECT-1:0] wp_sector,
  output logic              arr_start,
  output logic [1:0]        arr_op,
  output logic [SNB_W-1:0]  arr_sector,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [1:0]        arr_size,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic              arr_done
);
  logic             unlocked, pg, strt_req, cmd_ser, cmd_mer, launch, busy, stat_wr;
  logic [1:0]       psize;
  logic [SNB_W-1:0] cmd_snb;
  logic [31:0]      ctrl_rd;
  err_t             err_set, flags, stat_clr;
  op_e              op_q;

  assign stat_wr = cfg_we && (cfg_addr == OFS_STAT);
  always_comb begin
    stat_clr = '0;
    if (stat_wr) begin
      stat_clr.seq = cfg_wdata[SB_SEQ];
      stat_clr.par = cfg_wdata[SB_PAR];
      stat_clr.aln = cfg_wdata[SB_ALN];
      stat_clr.wrp = cfg_wdata[SB_WRP];
      stat_clr.ope = cfg_wdata[SB_OPE];
    end
  end

  fpe_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .unlocked(unlocked), .pg(pg), .psize(psize), .strt_req(strt_req),
    .cmd_ser(cmd_ser), .cmd_mer(cmd_mer), .cmd_snb(cmd_snb), .ctrl_rd(ctrl_rd)
  );

  fpe_launch u_launch (
    .clk(clk), .rst_n(rst_n), .strt_req(strt_req), .cmd_ser(cmd_ser), .cmd_mer(cmd_mer),
    .cmd_snb(cmd_snb), .unlocked(unlocked), .pg(pg), .psize(psize), .busy(busy),
    .fw_valid(fw_valid), .fw_addr(fw_addr), .fw_size(fw_size), .fw_data(fw_data),
    .wp(wp_sector), .err_set(err_set), .launch(launch), .arr_start(arr_start),
    .arr_op(op_q), .arr_sector(arr_sector), .arr_addr(arr_addr), .arr_size(arr_size),
    .arr_wdata(arr_wdata)
  );

  fpe_status u_status (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .err_set(err_set), .launch(launch),
    .arr_done(arr_done), .flags(flags), .busy(busy)
  );

  assign arr_op = op_q;

  always_comb begin
    case (cfg_addr)
      OFS_STAT: cfg_rdata = stat_word(flags, busy);
      OFS_CTRL: cfg_rdata = ctrl_rd;
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fpe_chk.sv
module fpe_chk
  import fpe_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              arr_start,
  input logic              arr_done,
  input logic [1:0]        arr_op,
  input logic [SNB_W-1:0]  arr_sector,
  input logic              unlocked,
  input logic [4:0]        flags,
  input logic              stat_wr,
  input logic [31:0]       ctrl_rd,
  input logic [N_SECT-1:0] wp_sector
);
  logic [SN_EXT-1:0] wp_q;
  always_ff @(posedge clk) wp_q <= SN_EXT'(wp_sector);

  // R5
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> busy);
  // R10
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> !$past(busy));
  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(arr_done));
  // R2
  start_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> $past(unlocked));
  // R3
  locked_ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(unlocked) |-> $stable(ctrl_rd[30:0]));
  // R13
  flag_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(stat_wr));
  // R11
  no_protected_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_start && arr_op != 2'd3) |-> !wp_q[arr_sector]);
endmodule

bind flash_pe_ctrl fpe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .arr_start(arr_start), .arr_done(arr_done),
  .arr_op(arr_op), .arr_sector(arr_sector), .unlocked(unlocked), .flags(flags),
  .stat_wr(stat_wr), .ctrl_rd(ctrl_rd), .wp_sector(wp_sector)
);

// File: tb/tb_flash_pe_ctrl.sv
`timescale 1ns/1ps
module tb_flash_pe_ctrl;
  import fpe_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fw_valid = 1'b0;
  logic [19:0] fw_addr = '0;
  logic [1:0]  fw_size = '0;
  logic [63:0] fw_data = '0;
  logic [11:0] wp_sector = '0;
  logic        arr_start;
  logic [1:0]  arr_op;
  logic [3:0]  arr_sector;
  logic [19:0] arr_addr;
  logic [1:0]  arr_size;
  logic [63:0] arr_wdata;
  logic        arr_done = 1'b0;

  int checks = 0;
  int fails = 0;
  int lat = 3;
  int cnt = 0;

  always #10 clk = ~clk;

  flash_pe_ctrl dut (.*);

  // Array model: done pulses lat cycles after a start.
  always_ff @(posedge clk) begin
    if (arr_start) begin
      cnt <= lat;
      arr_done <= 1'b0;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      arr_done <= (cnt == 1);
    end else arr_done <= 1'b0;
  end

  localparam logic [31:0] PG = 32'h1, SER = 32'h2, MER = 32'h4, STRT = 32'h1_0000;
  localparam logic [31:0] BSYB = 32'h1_0000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; fw_valid = 1'b0; wp_sector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fw(input logic [19:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    fw_valid = 1'b1; fw_addr = a; fw_size = s; fw_data = d;
    @(negedge clk);
    fw_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic unlock();
    wr(OFS_KEY, 32'h4567_0123);
    wr(OFS_KEY, 32'hCDEF_89AB);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      rd(OFS_STAT, s);
      if (!s[16]) break;
      @(negedge clk);
    end
  endtask

  // Bench view of the sector map.
  function automatic int bsec(input int a);
    if (a < 32'h1_0000) return a / 16384;
    if (a < 32'h2_0000) return 4;
    return 5 + (a - 32'h2_0000) / 32'h2_0000;
  endfunction

  function automatic logic [31:0] exp_prog(input int sz, input int ps, input int a, input logic [11:0] wp);
    if (sz != ps) return 32'h40;
    if ((a % (1 << sz)) != 0) return 32'h20;
    if (wp[bsec(a)]) return 32'h10;
    return 32'h0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'(checks), 64'h0);
    report();
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    do_reset();

    // R1
    rd(OFS_CTRL, r); chk(r == 32'h8000_0000, "R1 ctrl reset", 64'(r), 64'h8000_0000);
    rd(OFS_STAT, r); chk(r == 32'h0, "R1 status reset", 64'(r), 64'h0);
    chk(arr_start == 1'b0, "R1 start low", 64'(arr_start), 64'h0);

    // R3 locked write ignored
    wr(OFS_CTRL, PG | SER);
    rd(OFS_CTRL, r); chk(r == 32'h8000_0000, "R3 locked ctrl", 64'(r), 64'h8000_0000);

    // R2 unlock
    unlock();
    rd(OFS_CTRL, r); chk(r == 32'h0, "R2 unlocked ctrl", 64'(r), 64'h0);

    // R5 sector erase
    lat = 6;
    wr(OFS_CTRL, SER | (32'd3 << 3) | STRT);
    chk(arr_start && arr_op == 2'd2 && arr_sector == 4'd3, "R5 erase launch",
        {arr_start, arr_op, arr_sector}, {1'b1, 2'd2, 4'd3});
    rd(OFS_STAT, r); chk(r == BSYB, "R5 busy set", 64'(r), 64'(BSYB));
    // R10 start while busy
    wr(OFS_CTRL, SER | STRT);
    chk(arr_start == 1'b0, "R10 no restart", 64'(arr_start), 64'h0);
    rd(OFS_STAT, r); chk(r == (BSYB | 32'h80), "R10 busy seq", 64'(r), 64'(BSYB | 32'h80));
    wait_idle();
    rd(OFS_STAT, r); chk(r == 32'h80, "R5 busy cleared", 64'(r), 64'h80);
    wr(OFS_STAT, 32'hF2);

    // R10 start without erase bit
    wr(OFS_CTRL, STRT);
    rd(OFS_STAT, r); chk(r == 32'h80 && !arr_start, "R10 bare start", 64'(r), 64'h80);
    wr(OFS_STAT, 32'hF2);

    // R12 sector number out of range
    wr(OFS_CTRL, SER | (32'd13 << 3) | STRT);
    rd(OFS_STAT, r); chk(r == 32'h02 && !arr_start, "R12 bad sector", 64'(r), 64'h02);
    wr(OFS_STAT, 32'hF2);

    // R11 protected sector erase
    wp_sector = 12'h010;
    wr(OFS_CTRL, SER | (32'd4 << 3) | STRT);
    rd(OFS_STAT, r); chk(r == 32'h10 && !arr_start, "R11 protected erase", 64'(r), 64'h10);
    wr(OFS_STAT, 32'hF2);

    // R6 mass erase
    wr(OFS_CTRL, MER | STRT);
    rd(OFS_STAT, r); chk(r == 32'h10 && !arr_start, "R6 mass blocked", 64'(r), 64'h10);
    wr(OFS_STAT, 32'hF2);
    wp_sector = '0;
    wr(OFS_CTRL, MER | SER | STRT);
    chk(arr_start && arr_op == 2'd3, "R6 mass launch", {arr_start, arr_op}, {1'b1, 2'd3});
    wait_idle();

    // R10 program with PG clear
    wr(OFS_CTRL, 32'h0);
    fw(20'h0, 2'd1, 64'h1234);
    rd(OFS_STAT, r); chk(r == 32'h80 && !arr_start, "R10 no PG", 64'(r), 64'h80);
    wr(OFS_STAT, 32'hF2);

    // R13 collision: clear seq while a new seq fault arrives
    wr(OFS_CTRL, PG | (32'd1 << 8));
    fw(20'h0, 2'd2, 64'h0);
    rd(OFS_STAT, r); chk(r == 32'h40, "R8 width mismatch", 64'(r), 64'h40);
    wr(OFS_CTRL, 32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = OFS_STAT; cfg_wdata = 32'h80;
    fw_valid = 1'b1; fw_addr = 20'h0; fw_size = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; fw_valid = 1'b0;
    rd(OFS_STAT, r); chk(r == 32'hC0, "R13 set wins", 64'(r), 64'hC0);
    wr(OFS_STAT, 32'h80);
    rd(OFS_STAT, r); chk(r == 32'h40, "R13 single clear", 64'(r), 64'h40);
    wr(OFS_STAT, 32'h40);
    rd(OFS_STAT, r); chk(r == 32'h0, "R13 all clear", 64'(r), 64'h0);

    // R7 directed doubleword program
    lat = 2;
    wr(OFS_CTRL, PG | (32'd3 << 8));
    fw(20'h2_0008, 2'd3, 64'hDEAD_BEEF_0BAD_F00D);
    chk(arr_start && arr_op == 2'd1 && arr_sector == 4'd5 && arr_size == 2'd3 &&
        arr_addr == 20'h2_0008 && arr_wdata == 64'hDEAD_BEEF_0BAD_F00D,
        "R7 program launch", arr_wdata, 64'hDEAD_BEEF_0BAD_F00D);
    wait_idle();

    // R9 misaligned halfword
    wr(OFS_CTRL, PG | (32'd1 << 8));
    fw(20'h101, 2'd1, 64'h0);
    rd(OFS_STAT, r); chk(r == 32'h20 && !arr_start, "R9 misaligned", 64'(r), 64'h20);
    wr(OFS_STAT, 32'hF2);

    // R4 relock
    wr(OFS_CTRL, 32'h8000_0000 | PG);
    rd(OFS_CTRL, r); chk(r == 32'h8000_0001, "R4 relocked", 64'(r), 64'h8000_0001);
    wr(OFS_CTRL, SER);
    rd(OFS_CTRL, r); chk(r == 32'h8000_0001, "R4 locked ignores", 64'(r), 64'h8000_0001);
    fw(20'h0, 2'd0, 64'h0);
    rd(OFS_STAT, r); chk(r == 32'h80 && !arr_start, "R10 locked data write", 64'(r), 64'h80);

    // R3 wrong key freezes
    do_reset();
    wr(OFS_KEY, 32'h1234_5678);
    unlock();
    wr(OFS_CTRL, PG);
    rd(OFS_CTRL, r); chk(r == 32'h8000_0000, "R3 frozen", 64'(r), 64'h8000_0000);
    do_reset();
    unlock();
    rd(OFS_CTRL, r); chk(r == 32'h0, "R2 unlock after reset", 64'(r), 64'h0);

    // Random program traffic: R7 R8 R9 R11
    lat = 1;
    for (int it = 0; it < 60; it++) begin
      int ps, sz, a;
      logic [11:0] wp;
      logic [31:0] e;
      logic [63:0] d;
      ps = int'($urandom % 4);
      sz = (($urandom % 3) == 0) ? int'($urandom % 4) : ps;
      a  = int'($urandom % 32'h10_0000);
      if ($urandom % 2) a = a & ~((1 << sz) - 1);
      wp = ($urandom % 2) ? (12'h1 << ($urandom % 12)) : 12'h0;
      d  = {$urandom, $urandom};
      wp_sector = wp;
      e = exp_prog(sz, ps, a, wp);
      wr(OFS_CTRL, PG | (32'(ps) << 8));
      fw(20'(a), 2'(sz), d);
      chk(arr_start == (e == 0), "R7 random launch", 64'(arr_start), 64'(e == 0));
      if (e == 0)
        chk(arr_addr == 20'(a) && arr_op == 2'd1 && arr_sector == 4'(bsec(a)) && arr_wdata == d,
            "R7 random payload", {arr_sector, arr_addr}, {4'(bsec(a)), 20'(a)});
      wait_idle();
      rd(OFS_STAT, r);
      chk(r == e, "R8 R9 R11 random status", 64'(r), 64'(e));
      wr(OFS_STAT, 32'hF2);
    end

    report();
    $finish;
  end
endmodule